// File: doc/BRIEF.md
# Wide Galois LFSR Random Generator

This block produces a stream of 256-bit pseudo-random words from a right-shifting Galois linear feedback shift register. The polynomial is x^256 + x^255 + x^253 + x^252 + x^247 + 1. A compile-time parameter gives the starting state. A synchronous reset loads that state into the register. The block has no data inputs. A consumer raises the advance request for each word it wants. The register then steps once, and in the following cycle the whole new state word appears on the data output, qualified by a one-cycle valid flag.

A seed of zero would lock the register at zero for good. For that reason, a zero seed parameter is replaced by a fixed nonzero word, the all-ones value. The advance request can be held high to draw one fresh word per clock.

Top module: `wide_lfsr_rng`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the state is loaded with the seed and `rnd_vld_o` is 0. After the edge, `rnd_data_o` shows the seed.
- R2: Each step uses state bit 0 as the feedback bit. The step shifts the state right by one position and writes the feedback bit into bit 255.
- R3: When the feedback bit is 1, bits 254, 252, 251 and 246 of the shifted word are inverted. When it is 0, no bit is inverted.
- R4: A high `adv_i` at a rising edge advances the state by exactly one step. From that edge onward, `rnd_data_o` shows the new state, not the old one.
- R5: `rnd_vld_o` is 1 for the cycle after each edge at which `adv_i` was high. It is 0 after each edge at which `adv_i` was low, and it is 0 from reset until the first advance.
- R6: When `adv_i` is low at an edge, the state and `rnd_data_o` remain unchanged.
- R7: With `adv_i` held high for N consecutive edges, the state advances N steps, one per cycle, and `rnd_vld_o` stays high.
- R8: If the seed parameter is zero, the all-ones word is loaded in its place.
- R9: From the default seed 0xDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9, the first 10 advances match a reference model of the polynomial bit for bit.
- R10: Once out of reset, the state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the seed |
| adv_i | input | 1 | Advance request; one step per cycle it is high |
| rnd_data_o | output | 256 | Current register state (new word after an advance) |
| rnd_vld_o | output | 1 | High for one cycle after each advance |

## Verification
Two situations are hard to produce from the ports. The first is the zero-seed substitution, which no run of the default build can reach. The bench handles it by elaborating a second instance whose seed parameter is zero, then checking its reset word and its first advances. The second is a reset that arrives in the middle of a random run. The bench asserts reset between bursts of random advance requests and checks that the seed is reloaded. With random advance patterns, both the tapped step (feedback 1) and the plain shift (feedback 0) occur many times, and each step is compared with a bench model.

// File: rtl/lfsr_pkg.sv
// Package: shared word type, tap offsets and seed constants for the wide LFSR.
// Assumes: polynomial fixed at degree 256; tap offsets are measured from the MSB.
package lfsr_pkg;
    localparam int LFSR_W  = 256;
    localparam int N_TAPS  = 4;
    // Offsets below the MSB of the shifted-word bits inverted on feedback = 1.
    localparam int TAP_OFS [N_TAPS] = '{2, 4, 5, 10};

    typedef logic [LFSR_W-1:0] lfsr_word_t;

    localparam lfsr_word_t SEED_DEFAULT =
        256'hDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9;
    localparam lfsr_word_t SEED_FALLBACK = '1;

    // True when bit position pos of a width-w word receives feedback.
    function automatic bit is_tap(input int pos, input int w);
        bit hit;
        hit = 1'b0;
        for (int k = 0; k < N_TAPS; k++) begin
            if (pos == w - TAP_OFS[k]) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/lfsr_seed_sel.sv
// Module: lfsr_seed_sel
// Picks the reset value of the state register from the SEED parameter.
// Assumes: SEED is a constant. A zero seed is replaced by the fallback word,
// because the all-zero state never leaves itself.
module lfsr_seed_sel #(
    parameter int              WIDTH = lfsr_pkg::LFSR_W,
    parameter logic [WIDTH-1:0] SEED = lfsr_pkg::SEED_DEFAULT
) (
    output logic [WIDTH-1:0] seed_o
);
    localparam logic [WIDTH-1:0] FALLBACK = {WIDTH{1'b1}};

    // Select the seed once, at elaboration time.
    generate
        if (SEED == '0) begin : g_fallback
            assign seed_o = FALLBACK;
        end else begin : g_param
            assign seed_o = SEED;
        end
    endgenerate
endmodule

// File: rtl/lfsr_step.sv
// Module: lfsr_step
// Combinational single step of the right-shifting Galois LFSR.
// Assumes: tap positions come from lfsr_pkg and are relative to WIDTH.
// Every output bit is one XOR deep at most.
module lfsr_step #(
    parameter int WIDTH = lfsr_pkg::LFSR_W
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic fb;

    // Feedback bit is the bit shifted out at the bottom.
    assign fb = cur_i[0];

    // The MSB takes the feedback bit.
    assign nxt_o[WIDTH-1] = fb;

    // Lower bits take their upper neighbour, XORed with the feedback at taps.
    generate
        for (genvar i = 0; i < WIDTH - 1; i++) begin : g_bit
            if (lfsr_pkg::is_tap(i, WIDTH)) begin : g_tap
                assign nxt_o[i] = cur_i[i+1] ^ fb;
            end else begin : g_pass
                assign nxt_o[i] = cur_i[i+1];
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_vld_gen.sv
// Module: lfsr_vld_gen
// Registers the advance request into a one-cycle output valid flag.
// Assumes: synchronous active-low reset; the flag lines up with the
// cycle in which the state register shows the new word.
module lfsr_vld_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic vld_o
);
    // Delay the request by one edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= adv_i;
    end

    // R5: valid follows each request by exactly one cycle.
    assert_vld_after_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> vld_o);
    assert_vld_low_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> !vld_o);
endmodule

// File: rtl/wide_lfsr_rng.sv
// Module: wide_lfsr_rng (top)
// 256-bit Galois LFSR random word source. The reset loads the seed. Each cycle
// with adv_i high steps the register once. The state is the data output, and
// the valid flag marks the cycle after the step.
// Assumes: synchronous active-low reset; no runtime reseeding.
module wide_lfsr_rng #(
    parameter logic [lfsr_pkg::LFSR_W-1:0] SEED = lfsr_pkg::SEED_DEFAULT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv_i,
    output logic [lfsr_pkg::LFSR_W-1:0] rnd_data_o,
    output logic                        rnd_vld_o
);
    localparam int W = lfsr_pkg::LFSR_W;

    logic [W-1:0] seed_w;
    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;

    lfsr_seed_sel #(.WIDTH(W), .SEED(SEED)) i_seed (
        .seed_o (seed_w)
    );

    lfsr_step #(.WIDTH(W)) i_step (
        .cur_i (state_q),
        .nxt_o (state_nxt)
    );

    lfsr_vld_gen i_vld (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (adv_i),
        .vld_o (rnd_vld_o)
    );

    // State register: seed on reset, one step per request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= seed_w;
        else if (adv_i) state_q <= state_nxt;
    end

    // The output shows the state, so after a step it carries the new word.
    assign rnd_data_o = state_q;

    // R1: a reset edge leaves the seed in place and the valid flag low.
    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == seed_w) && !rnd_vld_o);
    // R6: without a request the word holds.
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q));
    // R2: after a step the MSB holds the bit shifted out of the LSB.
    assert_msb_feedback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> state_q[W-1] == $past(state_q[0]));
    // R10: the register never reaches the locked all-zero state.
    assert_never_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q != '0);
endmodule

// File: tb/test_wide_lfsr_rng.sv
`timescale 1ns/1ps
module test_wide_lfsr_rng;
    localparam logic [255:0] DEF_SEED =
        256'hDEADBEEFCAFEBABEFEEDFACEDECAFBAD1234567887654321ABCDEF010FEDCBA9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv = 1'b0;
    logic         adv_z = 1'b0;
    logic [255:0] dout, dout_z;
    logic         vld, vld_z;

    int n_tests = 0;
    int n_fail  = 0;
    logic [255:0] exp_s, exp_z;

    always #2 clk = ~clk;

    wide_lfsr_rng i_wide_lfsr_rng (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .rnd_data_o(dout), .rnd_vld_o(vld));

    wide_lfsr_rng #(.SEED('0)) i_wide_lfsr_rng_zero (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_z), .rnd_data_o(dout_z), .rnd_vld_o(vld_z));

    // Reference step built from the polynomial description.
    function automatic logic [255:0] ref_step(input logic [255:0] s);
        logic [255:0] n;
        n = (s >> 1) | ({255'd0, s[0]} << 255);
        if (s[0]) begin
            n[254] = ~n[254];
            n[252] = ~n[252];
            n[251] = ~n[251];
            n[246] = ~n[246];
        end
        return n;
    endfunction

    task automatic chk_w(input string req, input logic [255:0] act, input logic [255:0] e);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, e);
        end
    endtask

    task automatic chk_b(input string req, input logic act, input logic e);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", req, act, e);
        end
    endtask

    // Drive one request value, pass one edge, update the model, check at negedge.
    task automatic tick(input logic a, input string req);
        adv = a;
        @(posedge clk);
        @(negedge clk);
        if (a) exp_s = ref_step(exp_s);
        chk_w(req, dout, exp_s);
        chk_b({req, "_vld"}, vld, a);
    endtask

    task automatic do_reset;
        adv = 1'b0; adv_z = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_s = DEF_SEED;
        exp_z = '1;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7301));
        @(negedge clk);
        do_reset();
        // R1: seed shown and valid low after reset
        chk_w("R1", dout, DEF_SEED);
        chk_b("R1_vld", vld, 1'b0);
        // R8: zero seed replaced by all ones
        chk_w("R8", dout_z, '1);

        // R3/R2: first step from the default seed has feedback 1 (seed bit 0 set)
        tick(1'b1, "R3");
        n_tests++;
        if (dout[254] !== ~DEF_SEED[255] || dout[246] !== ~DEF_SEED[247] ||
            dout[255] !== 1'b1 || dout[253] !== DEF_SEED[254]) begin
            n_fail++;
            $display("FAIL R2 act=%h exp=%h", dout, ref_step(DEF_SEED));
        end
        // R9: ten consecutive advances from the default seed, R7 held high
        for (int i = 1; i < 10; i++) tick(1'b1, "R9");
        // R6: idle cycles hold the word
        for (int i = 0; i < 3; i++) tick(1'b0, "R6");
        // R4: single pulse steps exactly once
        tick(1'b1, "R4");
        tick(1'b0, "R4");

        // R8: zero-seed instance steps from all ones
        adv_z = 1'b1;
        @(posedge clk); @(negedge clk);
        adv_z = 1'b0;
        exp_z = ref_step(exp_z);
        chk_w("R8_step", dout_z, exp_z);
        chk_b("R8_vld", vld_z, 1'b1);

        // Random request pattern with mid-run resets (R1, R5, R7, R10)
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 80; i++) tick(logic'($urandom_range(0, 1)), "R5");
            for (int i = 0; i < 8; i++) tick(1'b1, "R7");
            n_tests++;
            if (dout == '0) begin
                n_fail++;
                $display("FAIL R10 act=%h exp=nonzero", dout);
            end
            do_reset();
            chk_w("R1_mid", dout, DEF_SEED);
            chk_b("R1_mid_vld", vld, 1'b0);
        end
        finish_run();
    end
endmodule